// File: doc/BRIEF.md
# EEPROM Station-Address Loader

At boot this sequencer reads a serial configuration EEPROM through a word-level request/response master and recovers the 48-bit station (MAC) address. It does not drive EEPROM pins itself. It asks the master for one 16-bit word at a time, giving a word address and an addressing-width flag, and waits for the matching response. The master handles all serial timing.

A run begins with a probe read of word 0 in narrow (6-bit) addressing. A part that needs 8-bit addressing answers a narrow probe with all ones, so a probe result of 0xFFFF switches the rest of the run to wide addressing. The sequencer then reads words 0 to 63 in ascending order. While it reads, it keeps a 16-bit running sum of every word and captures words 0 to 2 as the six address bytes. When the last word arrives, it raises `done`. It also raises `checksum_ok` if the sum equals the fixed signature 0xBABA. The address output is released only when the signature matches, and is zero in every other case.

States are IDLE, PROBE_REQ, PROBE_WAIT, READ_REQ, READ_WAIT and DONE. The transitions are:
- IDLE to PROBE_REQ on start.
- PROBE_REQ to PROBE_WAIT on request accept.
- PROBE_WAIT to READ_REQ on response, latching the width.
- READ_REQ to READ_WAIT on request accept.
- READ_WAIT to READ_REQ on a response that is not the last.
- READ_WAIT to DONE on the response to word 63.
- DONE to PROBE_REQ on start.

Top module: `mac_eeprom_loader`

## Requirements
- R1: After reset, `done`, `checksum_ok` and `req_valid` are 0 and `mac_addr` is all zeros.
- R2: The first request after an accepted start is word address 0 with `req_wide` = 0 (narrow, 6-bit addressing).
- R3: If the probe response is 0xFFFF, every later request of the run carries `req_wide` = 1 (8-bit addressing); otherwise every later request carries `req_wide` = 0.
- R4: After the probe, exactly 64 requests are issued, for word addresses 0, 1, ..., 63 in that order. A request whose `req_ready` is low keeps `req_valid`, `req_addr` and `req_wide` unchanged until it is accepted.
- R5: `checksum_ok` is 1 only when the sum modulo 2^16 of the 64 read words equals 0xBABA.
- R6: With a good checksum, `mac_addr[47:40]` holds the low byte of word 0 and `mac_addr[39:32]` its high byte. Bits [31:16] hold word 1 and bits [15:0] hold word 2, in the same low-then-high byte order.
- R7: With a bad checksum, `mac_addr` is all zeros.
- R8: `done` and `checksum_ok` are updated in the cycle after the response to word 63 is taken. `done` then stays 1 with no requests issued until the next `start`, which clears `done` and begins a new run.
- R9: A `start` asserted while a run is in progress has no effect: the request stream continues without a new probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load sequence (taken in IDLE or DONE) |
| req_valid | output | 1 | Read request to the EEPROM master is pending |
| req_ready | input | 1 | Master accepts the pending request |
| req_addr | output | 8 | Word address of the request |
| req_wide | output | 1 | 1 = 8-bit addressing, 0 = 6-bit addressing |
| resp_valid | input | 1 | Read data is valid for one cycle |
| resp_data | input | 16 | Word returned by the master |
| mac_addr | output | 48 | Station address, byte 0 in bits [47:40]; zero unless the checksum is good |
| checksum_ok | output | 1 | Image sum matched 0xBABA (valid with `done`) |
| done | output | 1 | Sequence finished; held until the next start |

## Verification
The bench uses an EEPROM model that returns all ones to a request in the wrong address width. This tests both outcomes of the probe. If the width decision were wrong, latched at the wrong time, or inverted, every read would return 0xFFFF and a scoreboard of expected requests would flag the width mismatch. The master's ready signal is throttled pseudo-randomly, so an address that advanced before acceptance would show up as a skipped or repeated word. A bad-sum image checks that the address output is forced to zero instead of leaking the captured bytes. A swapped byte order in the address shows up on the good-sum images. A start pulse in the middle of a run must not cause a second probe, and a start after completion must clear `done` and repeat the whole sequence.

// File: rtl/mel_pkg.sv
package mel_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE_REQ,
        ST_PROBE_WAIT,
        ST_READ_REQ,
        ST_READ_WAIT,
        ST_DONE
    } ld_state_t;
endpackage

// File: rtl/mel_seq_ctrl.sv
module mel_seq_ctrl
    import mel_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_ready,
    input  logic              resp_valid,
    input  logic [DATA_W-1:0] resp_data,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_wide,
    output logic              clear,
    output logic              word_take,
    output logic [$clog2(WORDS)-1:0] word_idx,
    output logic              done
);
    localparam int IDX_W = $clog2(WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);
    localparam logic [DATA_W-1:0] BLANK   = {DATA_W{1'b1}};

    ld_state_t       state, state_nx;
    logic [IDX_W-1:0] idx_q;
    logic            wide_q;
    logic            last_word;
    logic            busy;

    assign last_word = (idx_q == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start)      state_nx = ST_PROBE_REQ;
            ST_PROBE_REQ:  if (req_ready)  state_nx = ST_PROBE_WAIT;
            ST_PROBE_WAIT: if (resp_valid) state_nx = ST_READ_REQ;
            ST_READ_REQ:   if (req_ready)  state_nx = ST_READ_WAIT;
            ST_READ_WAIT:  if (resp_valid) state_nx = last_word ? ST_DONE : ST_READ_REQ;
            ST_DONE:       if (start)      state_nx = ST_PROBE_REQ;
            default:                       state_nx = ST_IDLE;
        endcase
    end

    // word index and address-width register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            wide_q <= 1'b0;
        end else begin
            if (clear) begin
                idx_q  <= '0;
                wide_q <= 1'b0;
            end
            if (state == ST_PROBE_WAIT && resp_valid)
                wide_q <= (resp_data == BLANK);
            if (state == ST_READ_WAIT && resp_valid && !last_word)
                idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        req_valid = 1'b0;
        req_addr  = ADDR_W'(idx_q);
        req_wide  = wide_q;
        clear     = 1'b0;
        word_take = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy  = 1'b0;
                clear = start;
            end
            ST_PROBE_REQ: begin
                req_valid = 1'b1;
                req_addr  = '0;
                req_wide  = 1'b0;
            end
            ST_PROBE_WAIT: begin
                req_addr = '0;
                req_wide = 1'b0;
            end
            ST_READ_REQ:  req_valid = 1'b1;
            ST_READ_WAIT: word_take = resp_valid;
            ST_DONE: begin
                busy  = 1'b0;
                done  = 1'b1;
                clear = start;
            end
            default: busy = 1'b0;
        endcase
    end

    assign word_idx = idx_q;

    AST_PROBE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (req_valid && !req_wide && req_addr == '0)); // R2

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_wide))); // R4

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_WAIT && resp_valid && !last_word) |=> (req_addr == $past(req_addr) + 1'b1)); // R4

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && !req_valid)); // R8

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state != ST_PROBE_REQ || $past(state) == ST_PROBE_REQ)); // R9
endmodule

// File: rtl/mel_sum_mac.sv
module mel_sum_mac #(
    parameter int                WORDS     = 64,
    parameter int                DATA_W    = 16,
    parameter int                MAC_WORDS = 3,
    parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        take,
    input  logic [$clog2(WORDS)-1:0]    idx,
    input  logic [DATA_W-1:0]           data,
    input  logic                        done,
    output logic                        checksum_ok,
    output logic [MAC_WORDS*DATA_W-1:0] mac_addr
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int MAC_W = MAC_WORDS * DATA_W;
    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] sum_q;
    logic [MAC_W-1:0]  mac_q;
    logic [DATA_W-1:0] swapped;

    // low byte of each word goes first (most significant position)
    for (genvar b = 0; b < BYTES; b++) begin : g_swap
        assign swapped[(BYTES-1-b)*8 +: 8] = data[b*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sum_q <= '0;
        else if (clear) sum_q <= '0;
        else if (take)  sum_q <= sum_q + data;
    end

    for (genvar w = 0; w < MAC_WORDS; w++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mac_q[MAC_W-1-w*DATA_W -: DATA_W] <= '0;
            else if (take && idx == IDX_W'(w))
                mac_q[MAC_W-1-w*DATA_W -: DATA_W] <= swapped;
        end
    end

    assign checksum_ok = done && (sum_q == SIGNATURE);
    assign mac_addr    = checksum_ok ? mac_q : '0;

    AST_SUM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clear) |=> $stable(sum_q)); // R5

    AST_OK_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(checksum_ok) |-> $past(take)); // R8
endmodule

// File: rtl/mac_eeprom_loader.sv
module mac_eeprom_loader #(
    parameter int                WORDS     = 64,
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 16,
    parameter int                MAC_WORDS = 3,
    parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    output logic                        req_valid,
    input  logic                        req_ready,
    output logic [ADDR_W-1:0]           req_addr,
    output logic                        req_wide,
    input  logic                        resp_valid,
    input  logic [DATA_W-1:0]           resp_data,
    output logic [MAC_WORDS*DATA_W-1:0] mac_addr,
    output logic                        checksum_ok,
    output logic                        done
);
    localparam int IDX_W = $clog2(WORDS);

    logic             clear;
    logic             word_take;
    logic [IDX_W-1:0] word_idx;

    mel_seq_ctrl #(
        .WORDS  (WORDS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_wide   (req_wide),
        .clear      (clear),
        .word_take  (word_take),
        .word_idx   (word_idx),
        .done       (done)
    );

    mel_sum_mac #(
        .WORDS     (WORDS),
        .DATA_W    (DATA_W),
        .MAC_WORDS (MAC_WORDS),
        .SIGNATURE (SIGNATURE)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .take        (word_take),
        .idx         (word_idx),
        .data        (resp_data),
        .done        (done),
        .checksum_ok (checksum_ok),
        .mac_addr    (mac_addr)
    );
endmodule

// File: tb/test_mac_eeprom_loader.sv
`timescale 1ns/1ps
module test_mac_eeprom_loader;
    localparam logic [15:0] SIG = 16'hBABA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [7:0]  req_addr;
    logic        req_wide;
    logic        resp_valid = 1'b0;
    logic [15:0] resp_data = '0;
    logic [47:0] mac_addr;
    logic        checksum_ok;
    logic        done;

    always #2.5 clk = ~clk;

    mac_eeprom_loader i_mac_eeprom_loader (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_wide(req_wide),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .mac_addr(mac_addr), .checksum_ok(checksum_ok), .done(done)
    );

    typedef struct packed { logic probe; logic wide; logic [7:0] addr; } req_t;

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 0;
    logic [15:0] mem [64];
    logic        dev_wide = 0;
    logic        ready_slow = 0;
    logic        exp_ok = 0;
    req_t        exp_q[$];
    logic [7:0]  lfsr = 8'h5A;
    bit          pend = 0;
    logic [15:0] pend_data = '0;
    bit          chk_done_next = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // EEPROM model plus request monitor (scoreboard consumer)
    always @(negedge clk) begin
        if (!rst_n) begin
            resp_valid = 0; req_ready = 0; pend = 0; chk_done_next = 0;
        end else begin
            if (chk_done_next) begin
                check(done == 1'b1, "R8", "done after last word", done, 1);
                check(checksum_ok == exp_ok, "R8", "checksum_ok with done", checksum_ok, exp_ok);
                chk_done_next = 0;
            end
            resp_valid = 0;
            if (pend) begin
                resp_valid = 1; resp_data = pend_data; pend = 0;
                if (exp_q.size() == 0) chk_done_next = 1;
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            req_ready = ready_slow ? lfsr[0] : 1'b1;
            if (req_valid && req_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected request", {req_wide, req_addr}, 0);
                end else begin
                    req_t e;
                    e = exp_q.pop_front();
                    if (e.probe)
                        check(req_addr == 8'd0 && !req_wide, "R2", "probe request",
                              {req_wide, req_addr}, {e.wide, e.addr});
                    else begin
                        check(req_wide == e.wide, "R3", "address width", req_wide, e.wide);
                        check(req_addr == e.addr, "R4", "word address", req_addr, e.addr);
                    end
                end
                pend = 1;
                pend_data = (req_wide != dev_wide) ? 16'hFFFF : mem[req_addr[5:0]];
            end
        end
    end

    // driver: builds an image, pushes expected requests, runs the sequence
    task automatic run_case(input bit wide, input bit slow, input bit good,
                            input int seed, input bit poke_start);
        logic [15:0] sum;
        logic [47:0] exp_mac;
        int          waited;
        sum = '0;
        for (int i = 0; i < 64; i++) begin
            logic [31:0] h;
            h = 32'(seed) * 32'h9E3779B1 + 32'(i) * 32'h6F1D4A27;
            mem[i] = h[15:0] ^ h[31:16];
        end
        if (mem[0] == 16'hFFFF) mem[0] = 16'h1234;
        for (int i = 0; i < 63; i++) sum = sum + mem[i];
        mem[63] = SIG - sum + (good ? 16'd0 : 16'd1);
        exp_mac = {mem[0][7:0], mem[0][15:8], mem[1][7:0], mem[1][15:8], mem[2][7:0], mem[2][15:8]};
        dev_wide = wide; ready_slow = slow; exp_ok = good;
        exp_q.push_back('{probe: 1'b1, wide: 1'b0, addr: 8'd0});
        for (int i = 0; i < 64; i++) exp_q.push_back('{probe: 1'b0, wide: wide, addr: 8'(i)});
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        check(done == 1'b0, "R8", "start clears done", done, 0);
        if (poke_start) begin
            repeat (40) @(negedge clk);
            start = 1;
            @(negedge clk); start = 0;
        end
        waited = 0;
        while (!done && waited < 5000) begin @(negedge clk); waited++; end
        check(exp_q.size() == 0, "R4", "all 64 words requested", exp_q.size(), 0);
        check(checksum_ok == good, "R5", "checksum verdict", checksum_ok, good);
        if (good) check(mac_addr == exp_mac, "R6", "station address", mac_addr, exp_mac);
        else      check(mac_addr == 48'h0, "R7", "address forced to zero", mac_addr, 0);
        repeat (8) @(negedge clk);
        check(done && !req_valid, "R8", "done held, no requests", {done, req_valid}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !checksum_ok && !req_valid && mac_addr == 48'h0, "R1", "reset state",
              {done, checksum_ok, req_valid, mac_addr}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        run_case(0, 0, 1, 1, 0);
        run_case(1, 0, 1, 2, 0);
        run_case(0, 1, 0, 3, 0);
        run_case(1, 1, 1, 4, 1);   // R9: start mid-run
        run_case(1, 0, 0, 5, 0);
        run_case(0, 1, 1, 6, 1);   // R9
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog run did not complete actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule